// File: doc/BRIEF.md
# Corrected-Error Interrupt Vector Table Entry

This block is one programmable entry of a local interrupt controller's vector table. It turns corrected-error notification pulses into a request toward the processor core. Software programs a 32-bit control word over a simple register bus at a fixed offset. The word selects a vector, a delivery mode and a mask bit. When an error pulse arrives and the entry is unmasked, the block checks the programmed mode. It then raises exactly one of three request lines: a fixed interrupt carrying the vector, a system-management request, or a non-maskable request. The request holds until the core accepts it. While a request is outstanding, a read-only delivery-status bit reads as one.

Bad programming never reaches the core. A fixed-mode vector below 16 sets an illegal-vector flag. Any mode other than fixed, system-management or non-maskable sets an unsupported-mode flag. Both flags sit in a separate status register, and any write to that register clears them. Error pulses that arrive while a delivery is outstanding collapse into a single pending event. That event is evaluated once the core accepts the current request.

The controller has two states. `ST_IDLE` waits for an error pulse or a pending event. `ST_DELIVER` holds the request until the core accepts it.
- The transition *launch* goes from `ST_IDLE` to `ST_DELIVER`. It is taken when an unmasked event meets a legal mode and vector.
- The transition *accept* goes from `ST_DELIVER` back to `ST_IDLE`. It is taken on `core_accept`.
- A masked or rejected event takes the transition *drop*, which stays in `ST_IDLE`. A rejected event also sets its status flag.

Top module: `err_lvt_entry`

## Requirements
- R1: After reset the entry word at offset 0x2F0 reads 0x0001_0000 (only the mask, bit 16, set). The status word at offset 0x280 reads 0. All request outputs are low.
- R2: Entry bits 7:0 (vector), 10:8 (mode) and 16 (mask) read back as written. Every other entry bit reads 0 whatever was written. The status word shows only bit 0 (illegal vector) and bit 1 (unsupported mode). An unmapped offset reads 0.
- R3: While the mask bit is 1, an error pulse raises no request and sets no status flag.
- R4: In mode 000 with a vector from 16 to 255, an error pulse raises `fixed_req` from the next cycle on, with `fixed_vec` equal to the vector. The request holds steady until `core_accept`.
- R5: In mode 000 with a vector from 0 to 15, an error pulse raises no request and sets status bit 0.
- R6: Mode 010 raises `smi_req`. Mode 100 raises `nmi_req` whatever the vector, including vectors below 16, and sets no status flag.
- R7: Modes 001, 011, 101, 110 and 111 raise no request and set status bit 1.
- R8: Entry bit 12 reads 1 while a request is outstanding. It reads 0 from the cycle after `core_accept`.
- R9: Any number of error pulses during an outstanding delivery produce exactly one further delivery after the accept. That delivery is evaluated against the mask and mode in force at that time.
- R10: Any write to the status offset clears both status flags.
- R11: At most one of `fixed_req`, `smi_req` and `nmi_req` is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 12 | Register byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` (combinational) |
| err_evt | input | 1 | Corrected-error event pulse |
| core_accept | input | 1 | Core accepts the outstanding request |
| fixed_req | output | 1 | Fixed interrupt request |
| fixed_vec | output | 8 | Vector that goes with `fixed_req` |
| smi_req | output | 1 | System-management request |
| nmi_req | output | 1 | Non-maskable request |
| err_status | output | 2 | Bit 0 illegal vector, bit 1 unsupported mode |

## Verification
The bench builds the block with its default parameters: a 12-bit offset, the entry at 0x2F0, the status word at 0x280, 8-bit vectors and a legality floor of 16. These values put both sides of the legality boundary (15 and 16) and the top vector 255 within reach of direct programming. All eight mode encodings can also be reached. Because both offsets are real, the bench can test clearing the status word separately from programming the entry.

// File: rtl/lvt_pkg.sv
package lvt_pkg;

    // Delivery-mode encodings decoded by the entry
    localparam logic [2:0] MODE_FIXED = 3'b000;
    localparam logic [2:0] MODE_SMI   = 3'b010;
    localparam logic [2:0] MODE_NMI   = 3'b100;

    // Bit positions inside the entry word
    localparam int MODE_LSB  = 8;
    localparam int DSTAT_BIT = 12;
    localparam int MASK_BIT  = 16;

    typedef enum logic [1:0] {
        ACT_NONE  = 2'd0,
        ACT_FIXED = 2'd1,
        ACT_SMI   = 2'd2,
        ACT_NMI   = 2'd3
    } act_e;

    typedef enum logic {
        ST_IDLE    = 1'b0,
        ST_DELIVER = 1'b1
    } state_e;

endpackage

// File: rtl/lvt_regs.sv
module lvt_regs
    import lvt_pkg::*;
#(
    parameter int          ADDR_W    = 12,
    parameter int          VEC_W     = 8,
    parameter logic [11:0] ENTRY_OFS = 12'h2F0,
    parameter logic [11:0] STAT_OFS  = 12'h280
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    input  logic              dstat_i,
    input  logic [1:0]        status_i,
    output logic [VEC_W-1:0]  vec_o,
    output logic [2:0]        mode_o,
    output logic              mask_o,
    output logic              stat_clr_o
);

    localparam logic [ADDR_W-1:0] ENTRY_A = ADDR_W'(ENTRY_OFS);
    localparam logic [ADDR_W-1:0] STAT_A  = ADDR_W'(STAT_OFS);

    logic entry_wr;

    assign entry_wr   = bus_wr && (bus_addr == ENTRY_A);
    assign stat_clr_o = bus_wr && (bus_addr == STAT_A);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            vec_o  <= '0;
            mode_o <= MODE_FIXED;
            mask_o <= 1'b1;
        end else if (entry_wr) begin
            vec_o  <= bus_wdata[VEC_W-1:0];
            mode_o <= bus_wdata[MODE_LSB +: 3];
            mask_o <= bus_wdata[MASK_BIT];
        end
    end

    always_comb begin
        bus_rdata = '0;
        if (bus_addr == ENTRY_A) begin
            bus_rdata[VEC_W-1:0]       = vec_o;
            bus_rdata[MODE_LSB +: 3]   = mode_o;
            bus_rdata[DSTAT_BIT]       = dstat_i;
            bus_rdata[MASK_BIT]        = mask_o;
        end else if (bus_addr == STAT_A) begin
            bus_rdata[1:0] = status_i;
        end
    end

    // R1: the entry comes out of reset masked
    p_mask_after_reset_r1: assert property (@(posedge clk) !rst_n |=> mask_o);

    // R2: the delivery-status bit follows the controller, not the bus
    p_dstat_not_written_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == ENTRY_A) |-> (bus_rdata[DSTAT_BIT] == dstat_i));

endmodule

// File: rtl/lvt_classify.sv
module lvt_classify
    import lvt_pkg::*;
#(
    parameter int VEC_W     = 8,
    parameter int MIN_LEGAL = 16
) (
    input  logic [2:0]       mode_i,
    input  logic [VEC_W-1:0] vec_i,
    output act_e             act_o,
    output logic             bad_vec_o,
    output logic             bad_mode_o
);

    localparam logic [VEC_W-1:0] FLOOR = VEC_W'(MIN_LEGAL);

    always_comb begin
        act_o      = ACT_NONE;
        bad_vec_o  = 1'b0;
        bad_mode_o = 1'b0;
        case (mode_i)
            MODE_FIXED: begin
                if (vec_i < FLOOR) bad_vec_o = 1'b1;
                else               act_o     = ACT_FIXED;
            end
            MODE_SMI: act_o = ACT_SMI;
            MODE_NMI: act_o = ACT_NMI;
            default:  bad_mode_o = 1'b1;
        endcase
    end

    // R5/R7: a rejected setting never yields an action
    always_comb begin
        a_reject_no_act_r7: assert ((bad_vec_o || bad_mode_o) ? (act_o == ACT_NONE) : 1'b1);
    end

endmodule

// File: rtl/lvt_fsm.sv
module lvt_fsm
    import lvt_pkg::*;
#(
    parameter int VEC_W     = 8,
    parameter int MIN_LEGAL = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             err_evt,
    input  logic             core_accept,
    input  logic             mask_i,
    input  act_e             act_i,
    input  logic             bad_vec_i,
    input  logic             bad_mode_i,
    input  logic [VEC_W-1:0] vec_i,
    input  logic             stat_clr_i,
    output logic             busy_o,
    output logic             fixed_req,
    output logic [VEC_W-1:0] fixed_vec,
    output logic             smi_req,
    output logic             nmi_req,
    output logic [1:0]       status_o
);

    state_e           state_q, state_d;
    act_e             kind_q, kind_d;
    logic [VEC_W-1:0] vec_q, vec_d;
    logic             pend_q, pend_d;
    logic             ill_q, ill_d;
    logic             uns_q, uns_d;
    logic             trig;

    assign trig = err_evt || pend_q;

    // Next-state and bookkeeping logic
    always_comb begin
        state_d = state_q;
        kind_d  = kind_q;
        vec_d   = vec_q;
        pend_d  = pend_q;
        ill_d   = stat_clr_i ? 1'b0 : ill_q;
        uns_d   = stat_clr_i ? 1'b0 : uns_q;
        unique case (state_q)
            ST_IDLE: begin
                pend_d = 1'b0;
                if (trig && !mask_i) begin
                    if (act_i != ACT_NONE) begin
                        state_d = ST_DELIVER;   // launch
                        kind_d  = act_i;
                        vec_d   = vec_i;
                    end else begin              // drop with status
                        if (bad_vec_i)  ill_d = 1'b1;
                        if (bad_mode_i) uns_d = 1'b1;
                    end
                end
            end
            ST_DELIVER: begin
                if (err_evt) pend_d = 1'b1;
                if (core_accept) state_d = ST_IDLE;  // accept
            end
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            kind_q  <= ACT_NONE;
            vec_q   <= '0;
            pend_q  <= 1'b0;
            ill_q   <= 1'b0;
            uns_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            kind_q  <= kind_d;
            vec_q   <= vec_d;
            pend_q  <= pend_d;
            ill_q   <= ill_d;
            uns_q   <= uns_d;
        end
    end

    // Outputs
    always_comb begin
        busy_o    = 1'b0;
        fixed_req = 1'b0;
        smi_req   = 1'b0;
        nmi_req   = 1'b0;
        fixed_vec = '0;
        unique case (state_q)
            ST_IDLE: ;
            ST_DELIVER: begin
                busy_o    = 1'b1;
                fixed_req = (kind_q == ACT_FIXED);
                smi_req   = (kind_q == ACT_SMI);
                nmi_req   = (kind_q == ACT_NMI);
                fixed_vec = (kind_q == ACT_FIXED) ? vec_q : '0;
            end
        endcase
        status_o = {uns_q, ill_q};
    end

    // R11: never more than one request line
    p_one_request_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({fixed_req, smi_req, nmi_req}));

    // R5: a fixed request never carries an illegal vector
    p_fixed_vec_legal_r5: assert property (@(posedge clk) disable iff (!rst_n)
        fixed_req |-> (fixed_vec >= VEC_W'(MIN_LEGAL)));

    // R4: the request and its vector hold until accepted
    p_request_holds_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && !core_accept) |=> (busy_o && $stable(fixed_vec)
                                      && $stable({fixed_req, smi_req, nmi_req})));

    // R3: a masked entry never launches
    p_masked_no_launch_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && mask_i) |=> !busy_o);

    // R8: accept ends the delivery on the next cycle
    p_accept_ends_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && core_accept) |=> !busy_o);

    // R10: a status write with no new error leaves both flags clear
    p_status_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_clr_i && (busy_o || !trig || mask_i)) |=> (status_o == 2'b00));

endmodule

// File: rtl/err_lvt_entry.sv
module err_lvt_entry
    import lvt_pkg::*;
#(
    parameter int          ADDR_W    = 12,
    parameter int          VEC_W     = 8,
    parameter int          MIN_LEGAL = 16,
    parameter logic [11:0] ENTRY_OFS = 12'h2F0,
    parameter logic [11:0] STAT_OFS  = 12'h280
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    input  logic              err_evt,
    input  logic              core_accept,
    output logic              fixed_req,
    output logic [VEC_W-1:0]  fixed_vec,
    output logic              smi_req,
    output logic              nmi_req,
    output logic [1:0]        err_status
);

    logic [VEC_W-1:0] vec;
    logic [2:0]       mode;
    logic             mask;
    logic             stat_clr;
    logic             busy;
    act_e             act;
    logic             bad_vec;
    logic             bad_mode;

    lvt_regs #(
        .ADDR_W(ADDR_W), .VEC_W(VEC_W),
        .ENTRY_OFS(ENTRY_OFS), .STAT_OFS(STAT_OFS)
    ) u_regs (
        .clk(clk), .rst_n(rst_n),
        .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .dstat_i(busy), .status_i(err_status),
        .vec_o(vec), .mode_o(mode), .mask_o(mask),
        .stat_clr_o(stat_clr)
    );

    lvt_classify #(.VEC_W(VEC_W), .MIN_LEGAL(MIN_LEGAL)) u_cls (
        .mode_i(mode), .vec_i(vec),
        .act_o(act), .bad_vec_o(bad_vec), .bad_mode_o(bad_mode)
    );

    lvt_fsm #(.VEC_W(VEC_W), .MIN_LEGAL(MIN_LEGAL)) u_fsm (
        .clk(clk), .rst_n(rst_n),
        .err_evt(err_evt), .core_accept(core_accept),
        .mask_i(mask), .act_i(act),
        .bad_vec_i(bad_vec), .bad_mode_i(bad_mode),
        .vec_i(vec), .stat_clr_i(stat_clr),
        .busy_o(busy),
        .fixed_req(fixed_req), .fixed_vec(fixed_vec),
        .smi_req(smi_req), .nmi_req(nmi_req),
        .status_o(err_status)
    );

endmodule

// File: tb/test_err_lvt_entry.sv
`timescale 1ns/1ps
module test_err_lvt_entry;

    localparam logic [11:0] A_ENT  = 12'h2F0;
    localparam logic [11:0] A_STAT = 12'h280;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [11:0] bus_addr = A_ENT;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        err_evt = 1'b0;
    logic        core_accept = 1'b0;
    logic        fixed_req, smi_req, nmi_req;
    logic [7:0]  fixed_vec;
    logic [1:0]  err_status;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    err_lvt_entry i_err_lvt_entry (
        .clk(clk), .rst_n(rst_n),
        .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .err_evt(err_evt), .core_accept(core_accept),
        .fixed_req(fixed_req), .fixed_vec(fixed_vec),
        .smi_req(smi_req), .nmi_req(nmi_req),
        .err_status(err_status)
    );

    // Row: {entry word, kind (0 none,1 fixed,2 smi,3 nmi), vector, status}
    localparam int NROWS = 11;
    localparam logic [43:0] ROWS [NROWS] = '{
        {32'h0000_0030, 2'd1, 8'h30, 2'b00},  // R4
        {32'h0000_00FF, 2'd1, 8'hFF, 2'b00},  // R4 top vector
        {32'h0000_0010, 2'd1, 8'h10, 2'b00},  // R4 floor
        {32'h0000_000F, 2'd0, 8'h00, 2'b01},  // R5
        {32'h0000_0200, 2'd2, 8'h00, 2'b00},  // R6 smi
        {32'h0000_0405, 2'd3, 8'h00, 2'b00},  // R6 nmi, low vector ignored
        {32'h0000_0530, 2'd0, 8'h00, 2'b10},  // R7 mode 101
        {32'h0000_0730, 2'd0, 8'h00, 2'b10},  // R7 mode 111
        {32'h0000_0330, 2'd0, 8'h00, 2'b10},  // R7 mode 011
        {32'h0000_0130, 2'd0, 8'h00, 2'b10},  // R7 mode 001
        {32'h0001_0030, 2'd0, 8'h00, 2'b00}   // R3 masked
    };

    task automatic check(input logic [31:0] act, input logic [31:0] exp, input string tag);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [11:0] a, output logic [31:0] d);
        bus_addr = a;
        #0.5;
        d = bus_rdata;
    endtask

    task automatic pulse_evt();
        @(negedge clk); err_evt = 1'b1;
        @(negedge clk); err_evt = 1'b0;
    endtask

    task automatic accept();
        @(negedge clk); core_accept = 1'b1;
        @(negedge clk); core_accept = 1'b0;
    endtask

    function automatic logic [2:0] reqs();
        return {fixed_req, smi_req, nmi_req};
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog all-requirements actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        rd(A_ENT, d);  check(d, 32'h0001_0000, "R1 entry reset");
        rd(A_STAT, d); check(d, 32'h0, "R1 status reset");
        check({29'b0, reqs()}, 32'h0, "R1 requests idle");

        // R2 read-only and reserved bits
        wr(A_ENT, 32'hFFFF_FFFF);
        rd(A_ENT, d);  check(d, 32'h0001_07FF, "R2 entry mask-off");
        rd(12'h100, d); check(d, 32'h0, "R2 unmapped offset");
        wr(A_ENT, 32'h0000_0000);
        rd(A_ENT, d);  check(d, 32'h0, "R2 entry cleared");

        // Table-driven: modes, boundaries, mask
        for (int i = 0; i < NROWS; i++) begin
            logic [31:0] ew;
            logic [1:0]  kd;
            logic [7:0]  vx;
            logic [1:0]  sx;
            logic [2:0]  er;
            {ew, kd, vx, sx} = ROWS[i];
            wr(A_STAT, 32'h0);
            wr(A_ENT, ew);
            pulse_evt();
            er = (kd == 2'd1) ? 3'b100 : (kd == 2'd2) ? 3'b010 : (kd == 2'd3) ? 3'b001 : 3'b000;
            check({29'b0, reqs()}, {29'b0, er}, $sformatf("R4/R6/R7/R3 row %0d request", i));
            if (kd == 2'd1) check({24'b0, fixed_vec}, {24'b0, vx}, $sformatf("R4 row %0d vector", i));
            if (kd != 2'd0) begin
                rd(A_ENT, d); check({31'b0, d[12]}, 32'h1, $sformatf("R8 row %0d dstat set", i));
                @(negedge clk);
                check({29'b0, reqs()}, {29'b0, er}, $sformatf("R4 row %0d held", i));
                accept();
                rd(A_ENT, d); check({31'b0, d[12]}, 32'h0, $sformatf("R8 row %0d dstat clear", i));
                check({29'b0, reqs()}, 32'h0, $sformatf("R8 row %0d request dropped", i));
            end
            rd(A_STAT, d); check(d, {30'b0, sx}, $sformatf("R5/R7 row %0d status", i));
            check({30'b0, err_status}, {30'b0, sx}, $sformatf("R5/R7 row %0d status pin", i));
        end

        // R10 status clear with both flags set
        wr(A_STAT, 32'h0);
        wr(A_ENT, 32'h0000_0005); pulse_evt();
        wr(A_ENT, 32'h0000_0600); pulse_evt();
        rd(A_STAT, d); check(d, 32'h3, "R10 both flags set");
        wr(A_STAT, 32'h0);
        rd(A_STAT, d); check(d, 32'h0, "R10 flags cleared");

        // R9 pending collapse
        wr(A_ENT, 32'h0000_0040);
        pulse_evt();
        pulse_evt();
        pulse_evt();
        check({29'b0, reqs()}, 32'h4, "R9 first delivery");
        accept();
        check({29'b0, reqs()}, 32'h0, "R9 gap after accept");
        @(negedge clk);
        check({29'b0, reqs()}, 32'h4, "R9 pending delivered");
        check({24'b0, fixed_vec}, 32'h40, "R9 pending vector");
        accept();
        repeat (3) @(negedge clk);
        check({29'b0, reqs()}, 32'h0, "R9 only one extra delivery");

        // R9 pending evaluated under new mask
        pulse_evt();
        pulse_evt();
        wr(A_ENT, 32'h0001_0040);
        accept();
        repeat (3) @(negedge clk);
        check({29'b0, reqs()}, 32'h0, "R9 pending dropped by mask");

        // R3 masked event leaves status untouched
        wr(A_ENT, 32'h0001_0005);
        pulse_evt();
        rd(A_STAT, d); check(d, 32'h0, "R3 masked no status");

        // R11 request lines exclusive under nmi
        wr(A_ENT, 32'h0000_0400);
        pulse_evt();
        check({29'b0, reqs()}, 32'h1, "R11 nmi only");
        accept();

        // R1 reset mid-delivery
        wr(A_ENT, 32'h0000_0020);
        pulse_evt();
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        rd(A_ENT, d); check(d, 32'h0001_0000, "R1 re-reset entry");
        check({29'b0, reqs()}, 32'h0, "R1 re-reset requests");

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule